// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter

A small up-counter (four bits by default) that can be preset from a parallel data word, cleared, held or advanced by one on each rising clock edge. All bits of the count update together on the edge, so no bit ripples into the next. Two build-time parameters select the variant. One picks the count range: binary (wraps after 15) or decade (wraps after 9). The other picks the clear style: clear acts on the next edge, or clear acts at once without waiting for the clock.

There are two active-high count enables. The first, the parallel enable, only gates counting. The second, the trickle enable, gates counting and also gates the terminal-count carry output. That carry is a combinational decode of the maximum count. Several counters can therefore be chained into a wider synchronous counter. Each stage's carry drives the trickle enable of the next, more significant stage. All stages share the clock and the parallel enable.

In synchronous-clear builds, a low-active decode of some count can be fed back into the clear input. The counter then returns to zero on the edge after that count, which gives a shortened count cycle.

Top module: `presettable_counter`

## Requirements
- R1: The count changes only on a rising clock edge, except for an asynchronous clear. A change on load, data or either enable between edges leaves the count unchanged.
- R2: With loadN low (and clear inactive), the next rising edge stores dataIn, whatever the levels of both enables.
- R3: clearN low forces the count to 0. With ASYNC_CLEAR=0 this takes effect at the next rising edge. With ASYNC_CLEAR=1 it takes effect at once, without a clock edge.
- R4: With clearN and loadN both high, the count rises by one at an edge only when enCount and enCarry are both 1. Otherwise the count holds.
- R5: The count wraps from its maximum to 0. The maximum is 15 when DECADE_MODE=0 and 9 when DECADE_MODE=1. In decade mode, a loaded value from 10 to 14 still counts up by one, and 15 wraps to 0.
- R6: carryOut is 1 exactly when enCarry is 1 and the count equals the maximum (15 binary, 9 decade). It follows enCarry immediately, with no clock edge.
- R7: At a clock edge, clear takes priority over load, load takes priority over counting, and counting takes priority over holding.
- R8: Two binary stages can be chained into an 8-bit counter. The low stage's carryOut drives the high stage's enCarry, and the enables and clock are shared. Together the two stages count through consecutive 8-bit values and wrap from 255 to 0.
- R9: With ASYNC_CLEAR=0, driving clearN low while the count equals N makes the counter return to 0 on the following edge, so it cycles through 0..N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous actions occur on its rising edge |
| clearN | input | 1 | Active-low clear to zero (synchronous or asynchronous per ASYNC_CLEAR) |
| loadN | input | 1 | Active-low synchronous parallel load |
| dataIn | input | COUNT_W | Parallel preset value |
| enCount | input | 1 | Parallel count enable; gates counting only |
| enCarry | input | 1 | Trickle count enable; gates counting and carryOut |
| countOut | output | COUNT_W | Current count |
| carryOut | output | 1 | Terminal-count carry: enCarry and count at maximum |

## Verification
The functions that collide most often are clear and load. The bench provokes this by holding both inputs low across one edge, with a preset value and enables that would otherwise change the count, and expects a zero count afterwards. Load is also made to coincide with every enable combination, and the bench expects the preset value to win. An asynchronous clear is made to fall half a cycle before an edge: the asynchronous variant must read zero at once, while the synchronous variant, fed the same inputs, must still show its old count until the edge.

// File: rtl/counter_pkg.sv
package counter_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic doClear;    // synchronous clear at the next edge
    logic doLoad;     // parallel preset at the next edge
    logic doInc;      // advance by one at the next edge
    logic carryGate;  // enables the terminal-count carry decode
  } ctrl_strobes_t;

endpackage

// File: rtl/counter_ctrl.sv
module counter_ctrl
  import counter_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic          clearN,
  input  logic          loadN,
  input  logic          enCount,
  input  logic          enCarry,
  output ctrl_strobes_t ctrl
);

  logic clrReq;

  // An asynchronous clear is applied directly on the register, so in that
  // variant no synchronous clear strobe is produced.
  generate
    if (ASYNC_CLEAR) begin : g_asyncClr
      assign clrReq = 1'b0;
    end else begin : g_syncClr
      assign clrReq = !clearN;
    end
  endgenerate

  // Priority: clear, then load, then count, then hold.
  always_comb begin
    ctrl.doClear   = clrReq;
    ctrl.doLoad    = !clrReq && !loadN;
    ctrl.doInc     = !clrReq && loadN && enCount && enCarry;
    ctrl.carryGate = enCarry;
  end

endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import counter_pkg::*;
#(
  parameter int COUNT_W     = 4,
  parameter bit DECADE_MODE = 1'b0,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic               clk,
  input  logic               clearN,
  input  ctrl_strobes_t      ctrl,
  input  logic [COUNT_W-1:0] dataIn,
  output logic [COUNT_W-1:0] countQ,
  output logic               carryOut
);

  localparam logic [COUNT_W-1:0] MAX_VAL =
    DECADE_MODE ? COUNT_W'(9) : {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] nextCount;
  logic               atMax;
  logic               primed = 1'b0;  // verification only: a clear has happened
  logic               asyncHold;

  assign atMax    = (countQ == MAX_VAL);
  assign carryOut = ctrl.carryGate && atMax;

  always_comb begin
    if (ctrl.doClear)     nextCount = '0;
    else if (ctrl.doLoad) nextCount = dataIn;
    else if (ctrl.doInc)  nextCount = atMax ? '0 : countQ + 1'b1;
    else                  nextCount = countQ;
  end

  generate
    if (ASYNC_CLEAR) begin : g_asyncReg
      always_ff @(posedge clk or negedge clearN) begin
        if (!clearN) begin
          countQ <= '0;
          primed <= 1'b1;
        end else begin
          countQ <= nextCount;
        end
      end
      // R3: the asynchronous clear holds the count at zero without a clock
      assert_async_clear_R3: assert property (@(posedge clk) disable iff (!primed)
        !clearN |-> countQ == '0);
    end else begin : g_syncReg
      always_ff @(posedge clk) begin
        countQ <= nextCount;
        if (ctrl.doClear) primed <= 1'b1;
      end
      // R3: the synchronous clear zeroes the count at the next edge
      assert_sync_clear_R3: assert property (@(posedge clk) disable iff (!primed)
        ctrl.doClear |=> countQ == '0);
    end
  endgenerate

  assign asyncHold = ASYNC_CLEAR && !clearN;

  // R2: a load strobe stores the data word
  assert_load_R2: assert property (@(posedge clk) disable iff (!primed || asyncHold)
    ctrl.doLoad |=> countQ == $past(dataIn));

  // R4: with no strobe the count holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!primed || asyncHold)
    !(ctrl.doClear || ctrl.doLoad || ctrl.doInc) |=> $stable(countQ));

  // R4: an increment below the maximum adds one
  assert_inc_R4: assert property (@(posedge clk) disable iff (!primed || asyncHold)
    (ctrl.doInc && countQ != MAX_VAL) |=> countQ == $past(countQ) + 1'b1);

  // R5: an increment at the maximum wraps to zero
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!primed || asyncHold)
    (ctrl.doInc && countQ == MAX_VAL) |=> countQ == '0);

  // R6: the carry is gated off whenever the trickle enable is low
  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!primed)
    !ctrl.carryGate |-> !carryOut);

  // R6: a carry that is counted through is followed by zero
  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (!primed || asyncHold)
    (carryOut && ctrl.doInc) |=> countQ == '0);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import counter_pkg::*;
#(
  parameter int COUNT_W     = 4,
  parameter bit DECADE_MODE = 1'b0,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic               clk,
  input  logic               clearN,
  input  logic               loadN,
  input  logic [COUNT_W-1:0] dataIn,
  input  logic               enCount,
  input  logic               enCarry,
  output logic [COUNT_W-1:0] countOut,
  output logic               carryOut
);

  ctrl_strobes_t ctrl;

  counter_ctrl #(
    .ASYNC_CLEAR(ASYNC_CLEAR)
  ) ctrl_i (
    .clearN (clearN),
    .loadN  (loadN),
    .enCount(enCount),
    .enCarry(enCarry),
    .ctrl   (ctrl)
  );

  counter_datapath #(
    .COUNT_W    (COUNT_W),
    .DECADE_MODE(DECADE_MODE),
    .ASYNC_CLEAR(ASYNC_CLEAR)
  ) dp_i (
    .clk     (clk),
    .clearN  (clearN),
    .ctrl    (ctrl),
    .dataIn  (dataIn),
    .countQ  (countOut),
    .carryOut(carryOut)
  );

endmodule

// File: tb/presettable_counter_tb_top.sv
module presettable_counter_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clrN = 1'b1, ldN = 1'b1, pIn = 1'b0, tIn = 1'b0;
  logic [3:0] dIn = 4'd0;
  logic [3:0] dutCount, decCount, loCount, hiCount;
  logic       dutCarry, decCarry, loCarry, hiCarry;

  int  checks = 0;
  int  failed = 0;
  bit  finished = 1'b0;
  bit  valid = 1'b0;
  logic [3:0] binM = 'x, decM = 'x, loM = 'x, hiM = 'x;

  // binary, synchronous clear
  presettable_counter #(.COUNT_W(4), .DECADE_MODE(1'b0), .ASYNC_CLEAR(1'b0)) dut_i (
    .clk(clk), .clearN(clrN), .loadN(ldN), .dataIn(dIn), .enCount(pIn), .enCarry(tIn),
    .countOut(dutCount), .carryOut(dutCarry));
  // decade, asynchronous clear
  presettable_counter #(.COUNT_W(4), .DECADE_MODE(1'b1), .ASYNC_CLEAR(1'b1)) dec_i (
    .clk(clk), .clearN(clrN), .loadN(ldN), .dataIn(dIn), .enCount(pIn), .enCarry(tIn),
    .countOut(decCount), .carryOut(decCarry));
  // two-stage cascade
  presettable_counter #(.COUNT_W(4), .DECADE_MODE(1'b0), .ASYNC_CLEAR(1'b0)) lo_i (
    .clk(clk), .clearN(clrN), .loadN(ldN), .dataIn(dIn), .enCount(pIn), .enCarry(tIn),
    .countOut(loCount), .carryOut(loCarry));
  presettable_counter #(.COUNT_W(4), .DECADE_MODE(1'b0), .ASYNC_CLEAR(1'b0)) hi_i (
    .clk(clk), .clearN(clrN), .loadN(ldN), .dataIn(dIn), .enCount(pIn), .enCarry(loCarry),
    .countOut(hiCount), .carryOut(hiCarry));

  // stimulus and expected binary count: {clearN, loadN, enCount, enCarry, data, expect}
  localparam int NVEC = 17;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0 },
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd12, 4'd12},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd13},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0 },
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd1 },
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd9,  4'd1 },
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd9,  4'd1 },
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd9,  4'd1 },
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  4'd7 },
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd8 },
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd9 },
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd10},
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd5,  4'd0 },
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd15, 4'd15},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd3,  4'd0 }
  };

  localparam logic [3:0] DSEQ [6] = '{4'd8, 4'd9, 4'd0, 4'd1, 4'd2, 4'd3};

  function automatic logic [3:0] modelNext(input logic [3:0] cur, input logic clr, input logic ld,
                                           input logic p, input logic t, input logic [3:0] d,
                                           input bit dec);
    logic [3:0] mx;
    mx = dec ? 4'd9 : 4'd15;
    if (!clr)        return 4'd0;
    else if (!ld)    return d;
    else if (p && t) return (cur == mx) ? 4'd0 : cur + 4'd1;
    else             return cur;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, check between edges, clock, check after.
  task automatic step(input logic clr, input logic ld, input logic p, input logic t,
                      input logic [3:0] d);
    logic loC;
    clrN = clr; ldN = ld; pIn = p; tIn = t; dIn = d;
    #1;
    if (valid) begin
      chk("R1 binary count unchanged before edge", {4'd0, dutCount}, {4'd0, binM});
      if (!clr) begin
        decM = 4'd0;
        chk("R3 asynchronous clear acts at once", {4'd0, decCount}, 8'd0);
      end else begin
        chk("R1 decade count unchanged before edge", {4'd0, decCount}, {4'd0, decM});
      end
      chk("R6 binary carry", {7'd0, dutCarry}, {7'd0, t && binM == 4'd15});
      chk("R6 decade carry", {7'd0, decCarry}, {7'd0, t && decM == 4'd9});
      chk("R6 low stage carry", {7'd0, loCarry}, {7'd0, t && loM == 4'd15});
    end
    loC = t && (loM == 4'd15);
    @(posedge clk);
    binM = modelNext(binM, clr, ld, p, t, d, 1'b0);
    decM = modelNext(decM, clr, ld, p, t, d, 1'b1);
    hiM  = modelNext(hiM, clr, ld, p, loC, d, 1'b0);
    loM  = modelNext(loM, clr, ld, p, t, d, 1'b0);
    @(negedge clk);
    chk("R7 binary model", {4'd0, dutCount}, {4'd0, binM});
    chk("R5 decade model", {4'd0, decCount}, {4'd0, decM});
    chk("R8 cascade low model", {4'd0, loCount}, {4'd0, loM});
    chk("R8 cascade high model", {4'd0, hiCount}, {4'd0, hiM});
    valid = 1'b1;
  endtask

  initial begin
    logic [3:0] e;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      chk("R7 table vector", {4'd0, dutCount}, {4'd0, VEC[i][3:0]});
      if (i == 0) chk("R3 reset state", {4'd0, dutCount}, 8'd0);
      if (i == 14) chk("R7 clear beats load", {4'd0, decCount}, 8'd0);
    end

    // every load value, enables varied; carry decode and its trickle gating
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 1'b0, v[0], v[1], 4'(v));
      chk("R2 load binary", {4'd0, dutCount}, 8'(v));
      chk("R2 load decade", {4'd0, decCount}, 8'(v));
      ldN = 1'b1; pIn = 1'b1; tIn = 1'b1; dIn = 4'(15 - v);
      #1;
      chk("R6 binary carry at max", {7'd0, dutCarry}, {7'd0, v == 15});
      chk("R6 decade carry at 9 only", {7'd0, decCarry}, {7'd0, v == 9});
      tIn = 1'b0;
      #1;
      chk("R6 enCarry low removes carry", {6'd0, dutCarry, decCarry}, 8'd0);
      chk("R1 inputs between edges leave count", {4'd0, dutCount}, 8'(v));
      step(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
      chk("R4 hold after load", {4'd0, dutCount}, 8'(v));
    end

    // enable combinations
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 4'd3);
      step(1'b1, 1'b1, c[1], c[0], 4'd0);
      chk("R4 count only with both enables", {4'd0, dutCount}, (c == 3) ? 8'd4 : 8'd3);
    end

    // decade sequence from 7
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
    for (int i = 0; i < 6; i++) begin
      pIn = 1'b1; tIn = 1'b1;
      #1;
      chk("R6 decade carry only at 9", {7'd0, decCarry}, {7'd0, decCount == 4'd9});
      step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      chk("R5 decade sequence", {4'd0, decCount}, {4'd0, DSEQ[i]});
    end

    // decade out-of-range values
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd14);
    step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R5 decade 14 counts to 15", {4'd0, decCount}, 8'd15);
    chk("R6 no decade carry at 15", {7'd0, decCarry}, 8'd0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R5 decade 15 wraps to 0", {4'd0, decCount}, 8'd0);

    // asynchronous against synchronous clear in the same half cycle
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd6);
    clrN = 1'b0; ldN = 1'b1;
    #1;
    chk("R3 async variant cleared before edge", {4'd0, decCount}, 8'd0);
    chk("R3 sync variant waits for edge", {4'd0, dutCount}, 8'd6);
    decM = 4'd0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R3 sync clear at edge", {4'd0, dutCount}, 8'd0);

    // shortened count via clear feedback at 5
    e = 4'd0;
    for (int i = 0; i < 14; i++) begin
      step(dutCount != 4'd5, 1'b1, 1'b1, 1'b1, 4'd0);
      e = (e == 4'd5) ? 4'd0 : e + 4'd1;
      chk("R9 truncated cycle", {4'd0, dutCount}, {4'd0, e});
    end

    // two-stage cascade
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd14);
    for (int n = 1; n <= 20; n++) begin
      step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      chk("R8 cascade value", {hiCount, loCount}, 8'(8'hEE + n));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, failed);
      $finish;
    end
  end

endmodule